// File: doc/BRIEF.md
# Reset and Power-Down Sequencer

This block collects the three ways a microcontroller-style system can be reset: an active-low external reset pin, a software request and a watchdog timeout. It turns any of them into one internal reset that lasts a fixed number of cycles after the last source goes away. An active-low indication output falls with every reset. It stays low past the end of the internal sequence and only rises when software strobes end of initialization. When a configuration bit is set, the block also pulls the external reset pin low for the whole internal sequence, so that parts outside the chip are reset as well.

The same block watches an active-low non-maskable interrupt pin. A falling edge produces a one-cycle trap request. The pin's level decides whether a power-down request is honoured. Both external inputs pass through two-flop synchronizers. The block only raises requests and status levels. Trap vectoring, clock generation and filtering of analog spikes belong elsewhere.

Top module: `rst_pwr_seq`

## Requirements
- R1: While `por_n` is low: `sys_rst_o` is 1, `rst_ind_n_o` is 0, `rst_pin_drv_o` is 0 and `trap_req_o` is 0.
- R2: A low level on `rst_pin_i` is synchronized through two flops. It starts a hardware reset only after the synchronized value has been low for two consecutive cycles. A low that is sampled at a single clock edge causes no reset. A low held over L ≥ 2 sampling edges keeps `sys_rst_o` high for L+RST_CYCLES−2 cycles.
- R3: Each software or watchdog request sampled at a clock edge sets `sys_rst_o` high. It falls RST_CYCLES edges after the last edge at which any source was sampled active, so a request held for L edges yields L+RST_CYCLES−1 high cycles.
- R4: Once the bidirectional bit has been written to 1 (`bidir_we_i`=1 with `bidir_d_i`=1), every reset sequence that starts afterwards, whatever its source, drives `rst_pin_drv_o` high for exactly the cycles `sys_rst_o` is high. While the bit is 0, `rst_pin_drv_o` stays 0.
- R5: The bidirectional bit is cleared by an accepted pin reset. Software and watchdog resets leave it unchanged.
- R6: While the block drives the pin, and for three cycles after it stops, a low pin does not start or extend a hardware reset.
- R7: `rst_ind_n_o` goes low with every reset source. It stays low after `sys_rst_o` falls, until `einit_i` is seen high outside reset. It then rises one cycle later.
- R8: An `einit_i` strobe while `sys_rst_o` is high has no effect.
- R9: A falling edge on `nmi_n_i` raises `trap_req_o` for exactly one cycle, in the third cycle after the edge has been sampled. A rising edge raises nothing.
- R10: `pwrdn_enter_o` equals `pwrdn_req_i` when the synchronized `nmi_n_i` is low, and is 0 when it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset of the block, active low |
| rst_pin_i | input | 1 | Level of the external reset pin, active low |
| rst_pin_drv_o | output | 1 | 1 = pull the external reset pin low |
| sw_rst_i | input | 1 | Software reset request |
| wdt_rst_i | input | 1 | Watchdog timeout reset request |
| bidir_we_i | input | 1 | Write strobe for the bidirectional bit |
| bidir_d_i | input | 1 | Value written to the bidirectional bit |
| einit_i | input | 1 | End-of-initialization strobe |
| sys_rst_o | output | 1 | Internal reset, active high |
| rst_ind_n_o | output | 1 | Reset indication, active low |
| nmi_n_i | input | 1 | Non-maskable interrupt pin, active low |
| trap_req_o | output | 1 | One-cycle trap request |
| pwrdn_req_i | input | 1 | Power-down request |
| pwrdn_enter_o | output | 1 | Power-down request accepted |

## Verification
The bench sweeps the hold length of each reset source. It counts the cycles of internal reset against the arithmetic formula, so an off-by-one in the counter or the pin filter shows up as a wrong count. A one-sample pin glitch is checked to be ignored. The pin is fed back from the drive output, so a missing blanking window would retrigger and give a longer count than expected. Two cases test the bidirectional bit: software and watchdog resets must keep it, and a pin reset must clear it. The end-of-init strobe is applied both during and after reset, which exposes an early release. The interrupt pin is swept across both edges and both levels against the power-down request, which exposes a trap on the wrong edge or power-down gating on the wrong level.

// File: rtl/rst_pwr_seq.sv
module rst_pwr_seq #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin_i,
  output logic rst_pin_drv_o,
  input  logic sw_rst_i,
  input  logic wdt_rst_i,
  input  logic bidir_we_i,
  input  logic bidir_d_i,
  input  logic einit_i,
  output logic sys_rst_o,
  output logic rst_ind_n_o,
  input  logic nmi_n_i,
  output logic trap_req_o,
  input  logic pwrdn_req_i,
  output logic pwrdn_enter_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [1:0]    pin_sy;
  logic          pin_lo;
  logic [2:0]    blank;
  logic [2:0]    nmi_sy;
  logic [CW-1:0] cnt;
  logic          bidir_q, drv_q, ind_q;
  logic          mask, hw_act, any_src;

  assign mask          = rst_pin_drv_o | (|blank);
  assign hw_act        = !pin_sy[1] & pin_lo & !mask;
  assign any_src       = hw_act | sw_rst_i | wdt_rst_i;
  assign sys_rst_o     = (cnt != '0);
  assign rst_pin_drv_o = drv_q & sys_rst_o;
  assign rst_ind_n_o   = !ind_q;
  assign trap_req_o    = nmi_sy[2] & !nmi_sy[1];
  assign pwrdn_enter_o = pwrdn_req_i & !nmi_sy[1];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pin_sy  <= 2'b11;
      pin_lo  <= 1'b0;
      blank   <= '0;
      nmi_sy  <= 3'b111;
      cnt     <= CW'(RST_CYCLES);
      bidir_q <= 1'b0;
      drv_q   <= 1'b0;
      ind_q   <= 1'b1;
    end else begin
      pin_sy <= {pin_sy[0], rst_pin_i};
      pin_lo <= !pin_sy[1] & !mask;
      blank  <= {blank[1:0], rst_pin_drv_o};
      nmi_sy <= {nmi_sy[1:0], nmi_n_i};

      if (any_src)        cnt <= CW'(RST_CYCLES);
      else if (sys_rst_o) cnt <= cnt - 1'b1;

      if (any_src && !sys_rst_o) drv_q <= bidir_q;
      else if (!sys_rst_o)       drv_q <= 1'b0;

      if (hw_act)          bidir_q <= 1'b0;
      else if (bidir_we_i) bidir_q <= bidir_d_i;

      if (any_src || sys_rst_o) ind_q <= 1'b1;
      else if (einit_i)         ind_q <= 1'b0;
    end
  end
endmodule

module rst_pwr_seq_chk (
  input logic clk,
  input logic por_n,
  input logic rst_pin_i,
  input logic rst_pin_drv_o,
  input logic sw_rst_i,
  input logic wdt_rst_i,
  input logic bidir_we_i,
  input logic bidir_d_i,
  input logic einit_i,
  input logic sys_rst_o,
  input logic rst_ind_n_o,
  input logic nmi_n_i,
  input logic trap_req_o,
  input logic pwrdn_req_i,
  input logic pwrdn_enter_o
);
  p_drive_inside_rst_r4: assert property (@(posedge clk) disable iff (!por_n)
    rst_pin_drv_o |-> sys_rst_o);
  p_ind_low_in_rst_r7: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst_o |-> !rst_ind_n_o);
  p_ind_release_r8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_ind_n_o) |-> ($past(einit_i) && !$past(sys_rst_o)));
  p_sw_starts_r3: assert property (@(posedge clk) disable iff (!por_n)
    (sw_rst_i || wdt_rst_i) |=> sys_rst_o);
  p_trap_single_r9: assert property (@(posedge clk) disable iff (!por_n)
    trap_req_o |=> !trap_req_o);
  p_pd_gated_r10: assert property (@(posedge clk) disable iff (!por_n)
    pwrdn_enter_o |-> pwrdn_req_i);
endmodule

bind rst_pwr_seq rst_pwr_seq_chk u_chk (.*);

// File: tb/tb_rst_pwr_seq.sv
module tb_rst_pwr_seq;
  localparam int N = 16;
  logic clk = 1'b0;
  logic por_n, ext_n, sw, wdt, bwe, bd, einit, nmi_n, pdreq;
  logic pin, drv, srst, ind_n, trap, pden;
  int errs = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign pin = ext_n & !drv;

  rst_pwr_seq #(.RST_CYCLES(N)) dut (
    .clk(clk), .por_n(por_n), .rst_pin_i(pin), .rst_pin_drv_o(drv),
    .sw_rst_i(sw), .wdt_rst_i(wdt), .bidir_we_i(bwe), .bidir_d_i(bd),
    .einit_i(einit), .sys_rst_o(srst), .rst_ind_n_o(ind_n),
    .nmi_n_i(nmi_n), .trap_req_o(trap), .pwrdn_req_i(pdreq),
    .pwrdn_enter_o(pden));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_bidir(input logic v);
    @(negedge clk); bwe = 1; bd = v;
    @(negedge clk); bwe = 0;
  endtask

  // kind: 0 pin, 1 software, 2 watchdog. Counts high cycles of srst/drv.
  task automatic pulse(input int kind, input int len, output int nr, output int nd, output int ind0);
    nr = 0; nd = 0; ind0 = 1;
    @(negedge clk);
    if (kind == 0) ext_n = 0; else if (kind == 1) sw = 1; else wdt = 1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (srst) nr++;
      if (drv) nd++;
      if (!ind_n) ind0 = 0;
    end
    ext_n = 1; sw = 0; wdt = 0;
    for (int i = 0; i < N + 12; i++) begin
      @(negedge clk);
      if (srst) nr++;
      if (drv) nd++;
    end
  endtask

  initial begin
    int nr, nd, i0, tcnt;
    por_n = 0; ext_n = 1; sw = 0; wdt = 0; bwe = 0; bd = 0;
    einit = 0; nmi_n = 1; pdreq = 0;
    repeat (3) @(negedge clk);
    chk("R1 sys_rst", srst, 1); chk("R1 ind_n", ind_n, 0);
    chk("R1 drv", drv, 0); chk("R1 trap", trap, 0);
    por_n = 1;
    repeat (N + 4) @(negedge clk);
    chk("R7 ind held after por", ind_n, 0);
    einit = 1; @(negedge clk); einit = 0;
    chk("R7 ind released", ind_n, 1);

    for (int l = 1; l <= 5; l++) begin
      pulse(0, l, nr, nd, i0);
      chk($sformatf("R2 pin len %0d", l), nr, (l >= 2) ? l + N - 2 : 0);
      chk("R4 no drive when clear", nd, 0);
      einit = 1; @(negedge clk); einit = 0;
    end
    for (int k = 1; k <= 2; k++)
      for (int l = 1; l <= 4; l++) begin
        pulse(k, l, nr, nd, i0);
        chk($sformatf("R3 src %0d len %0d", k, l), nr, l + N - 1);
        chk("R7 ind falls", i0, 0);
        chk("R7 ind held", ind_n, 0);
        einit = 1; @(negedge clk); einit = 0;
      end

    set_bidir(1);
    pulse(1, 3, nr, nd, i0);
    chk("R4 sw drive", nd, 3 + N - 1);
    chk("R6 no retrigger", nr, 3 + N - 1);
    pulse(2, 2, nr, nd, i0);
    chk("R5 kept over sw, R4 wdt drive", nd, 2 + N - 1);
    chk("R6 no retrigger wdt", nr, 2 + N - 1);
    pulse(0, 4, nr, nd, i0);
    chk("R4 pin drive", (nd > 0) ? 1 : 0, 1);
    pulse(1, 2, nr, nd, i0);
    chk("R5 cleared by pin", nd, 0);

    @(negedge clk); sw = 1; @(negedge clk); sw = 0;
    repeat (3) @(negedge clk);
    einit = 1; @(negedge clk); einit = 0;
    repeat (N + 4) @(negedge clk);
    chk("R8 einit in reset ignored", ind_n, 0);
    einit = 1; @(negedge clk); einit = 0;
    chk("R8 einit after reset", ind_n, 1);

    for (int e = 0; e < 4; e++) begin
      tcnt = 0;
      @(negedge clk); nmi_n = e[0];
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (trap) begin
          tcnt++;
          chk("R9 trap cycle", i, 1);
        end
      end
      chk($sformatf("R9 edge %0d", e), tcnt, (e[0] == 0) ? 1 : 0);
      for (int r = 0; r < 2; r++) begin
        pdreq = r[0]; #2;
        chk($sformatf("R10 nmi %0d req %0d", e[0], r), pden, r[0] & !e[0]);
        @(negedge clk); pdreq = 0;
      end
      chk("R9 idle", trap, 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule